// File: doc/BRIEF.md
# Multiplexed-Strobe Register Bus Slave with Burst Addressing

This block lets a host processor reach a 128-entry by 8-bit register array over a parallel bus with an address latch enable, an active-low chip select, separate active-low read and write strobes, a 7-bit address and an 8-bit data bus. The data bus is split into an input, an output and an output enable, so a pad or a bench can build the bidirectional pin. Every bus control and bus value crosses into the internal clock through two flip-flops. All edges are found from the synchronized copies.

A host starts an access by raising the latch enable with the address on the pins. While the latch enable is high the address register follows the pins. When the latch enable falls, the register keeps the starting address and the slave enters burst mode. Each completed read or write in burst mode then moves the latched address to the next entry. Raising the latch enable ends the burst. The same sequence also covers a single access: one strobe, then a new address phase.

Top module: `busreg_slave`

## Requirements
- R1: A synchronous reset clears the latched address to 0 and leaves burst mode off. After reset, with the latch enable held low, every completed write or read targets entry 0 and the address does not advance. During reset the output enable is low.
- R2: While the synchronized latch enable is high, the latched address follows the address pins. Its falling edge keeps the last address as the start of the access.
- R3: A rising edge of the write strobe stores the data pins into the entry at the latched address. This takes effect only while chip select is low and the read strobe is high.
- R4: The output enable is high exactly while the synchronized chip select and read strobe are both low. At that time data_out shows the entry at the latched address. When the output enable is low, data_out is 0.
- R5: In burst mode (after a falling edge of the latch enable, while it stays low), every completed write and every completed read (rising read strobe with chip select low) advances the latched address by one.
- R6: Advancing from address 127 wraps to address 0.
- R7: A rising edge of the latch enable ends burst mode. A write whose strobe rises in the same cycle lands at the old latched address, and the latch then follows the pins.
- R8: While chip select is high, no strobe edge writes an entry, changes the address or raises the output enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ale | input | 1 | Address latch enable, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 7 | Register address |
| data_in | input | 8 | Data bus input path |
| data_out | output | 8 | Data bus output path |
| data_oe | output | 1 | Data bus output enable |

## Verification
The end of a write and the end of a burst can fall in the same internal cycle: the write strobe and the latch enable rise together. The bench provokes this by changing wr_n, ale and the address pins at the same falling clock edge. Both signals then pass through the synchronizer together, so the write and the burst end are decoded in one cycle. The bench then reads back from the old address and from the new one. The written byte must appear only at the old latched address, and the next read must come from the address on the pins, with no stray increment.

// File: rtl/busreg_slave_pkg.sv
package busreg_slave_pkg;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_WR   = 2'd1,
        ACC_RD   = 2'd2
    } access_e;

    localparam int CTL_W = 4;

endpackage

// File: rtl/busreg_sync.sv
module busreg_sync #(
    parameter int              W       = 8,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/busreg_regfile.sv
module busreg_regfile #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/busreg_slave.sv
module busreg_slave #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              ale,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);
    import busreg_slave_pkg::*;

    localparam int SYNC_W = CTL_W + ADDR_W + DATA_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {4'b1011, {(ADDR_W + DATA_W){1'b0}}};

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              burst;
        logic              ale_p;
        logic              wr_p;
        logic              rd_p;
    } state_t;

    state_t state_d, state_q;

    logic [SYNC_W-1:0] sync_in, sync_out;
    logic              cs_s, ale_s, rd_s, wr_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic [DATA_W-1:0] rdata;
    access_e           acc;
    logic              wr_fire;
    logic              ale_fall, wr_rise, rd_rise, sel;

    assign sync_in = {cs_n, ale, rd_n, wr_n, addr, data_in};

    busreg_sync #(
        .W       (SYNC_W),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (sync_in),
        .dout (sync_out)
    );

    assign {cs_s, ale_s, rd_s, wr_s, addr_s, data_s} = sync_out;

    always_comb begin
        state_d  = state_q;
        sel      = ~cs_s;
        ale_fall = ~ale_s & state_q.ale_p;
        wr_rise  = wr_s & ~state_q.wr_p;
        rd_rise  = rd_s & ~state_q.rd_p;

        acc = ACC_NONE;
        if (sel && wr_rise && rd_s) begin
            acc = ACC_WR;
        end else if (sel && rd_rise && wr_s) begin
            acc = ACC_RD;
        end

        state_d.ale_p = ale_s;
        state_d.wr_p  = wr_s;
        state_d.rd_p  = rd_s;

        if (ale_s) begin
            state_d.addr  = addr_s;
            state_d.burst = 1'b0;
        end else begin
            if (ale_fall) begin
                state_d.burst = 1'b1;
            end
            if (acc != ACC_NONE && state_q.burst) begin
                state_d.addr = state_q.addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '{addr: '0, burst: 1'b0, ale_p: 1'b0, wr_p: 1'b1, rd_p: 1'b1};
        end else begin
            state_q <= state_d;
        end
    end

    assign wr_fire = (acc == ACC_WR);

    busreg_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk   (clk),
        .we    (wr_fire),
        .waddr (state_q.addr),
        .wdata (data_s),
        .raddr (state_q.addr),
        .rdata (rdata)
    );

    assign data_oe  = ~cs_s & ~rd_s;
    assign data_out = data_oe ? rdata : '0;
endmodule

// File: rtl/busreg_slave_chk.sv
module busreg_slave_chk #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              rd_n,
    input logic              data_oe,
    input logic [DATA_W-1:0] data_out,
    input logic              ale_s,
    input logic              wr_fire,
    input logic              burst_q,
    input logic [ADDR_W-1:0] addr_q
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (addr_q == '0 && !burst_q && !data_oe));

    assert_idle_output_R4: assert property (@(posedge clk) disable iff (rst)
        !data_oe |-> data_out == '0);

    assert_oe_needs_cs_R8: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> ($past(cs_n, 2) == 1'b0 && $past(rd_n, 2) == 1'b0));

    assert_write_needs_cs_R3: assert property (@(posedge clk) disable iff (rst)
        wr_fire |-> $past(cs_n, 2) == 1'b0);

    assert_burst_step_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && burst_q && !ale_s) |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

    assert_burst_end_R7: assert property (@(posedge clk) disable iff (rst)
        ale_s |=> !burst_q);
endmodule

bind busreg_slave busreg_slave_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .data_oe  (data_oe),
    .data_out (data_out),
    .ale_s    (ale_s),
    .wr_fire  (wr_fire),
    .burst_q  (state_q.burst),
    .addr_q   (state_q.addr)
);

// File: tb/tb_busreg_slave.sv
module tb_busreg_slave;
    logic       clk = 1'b0;
    logic       rst;
    logic       cs_n, ale, rd_n, wr_n;
    logic [6:0] addr;
    logic [7:0] data_in;
    logic [7:0] data_out;
    logic       data_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    busreg_slave dut (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .ale      (ale),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .addr     (addr),
        .data_in  (data_in),
        .data_out (data_out),
        .data_oe  (data_oe)
    );

    // {address, data} pairs for single programmed writes
    localparam logic [14:0] VEC [8] = '{
        {7'd5,  8'h3C}, {7'd16, 8'hC3}, {7'd42, 8'h01}, {7'd64, 8'h80},
        {7'd85, 8'h55}, {7'd99, 8'hAA}, {7'd30, 8'h11}, {7'd20, 8'h6E}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_addr(input logic [6:0] a);
        addr = a; ale = 1'b1; wait_n(4);
        ale = 1'b0; wait_n(4);
    endtask

    task automatic wr_pulse(input logic [7:0] d);
        data_in = d; wr_n = 1'b0; wait_n(4);
        wr_n = 1'b1; wait_n(4);
    endtask

    task automatic rd_pulse(output logic [7:0] d, output logic oe);
        rd_n = 1'b0; wait_n(4);
        d = data_out; oe = data_oe;
        rd_n = 1'b1; wait_n(4);
    endtask

    task automatic do_reset();
        cs_n = 1'b1; ale = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
        rst = 1'b1; wait_n(5);
        rst = 1'b0; wait_n(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        logic       oe;
        addr = '0; data_in = '0;
        do_reset();

        // R1 / R4: reset state at the ports
        check("R1 oe after reset", {7'd0, data_oe}, 8'h00);
        check("R4 data_out idle", data_out, 8'h00);

        // R2 / R3: table of single writes, then read back
        cs_n = 1'b0;
        for (int i = 0; i < 8; i++) begin
            set_addr(VEC[i][14:8]);
            wr_pulse(VEC[i][7:0]);
        end
        for (int i = 0; i < 8; i++) begin
            set_addr(VEC[i][14:8]);
            rd_pulse(rv, oe);
            check("R3 single write readback", rv, VEC[i][7:0]);
        end
        check("R4 oe during read", {7'd0, oe}, 8'h01);

        // R5 / R6: burst write across the wrap
        set_addr(7'd126);
        for (int i = 0; i < 4; i++) wr_pulse(8'hA0 + 8'(i));
        set_addr(7'd126);
        for (int i = 0; i < 4; i++) begin
            rd_pulse(rv, oe);
            check("R5 R6 burst wrap", rv, 8'hA0 + 8'(i));
        end

        // R8: chip select high ignores strobes
        cs_n = 1'b1;
        set_addr(7'd30);
        wr_pulse(8'hFF);
        rd_n = 1'b0; wait_n(4);
        check("R8 oe with cs high", {7'd0, data_oe}, 8'h00);
        rd_n = 1'b1; wait_n(4);
        cs_n = 1'b0;
        set_addr(7'd30);
        rd_pulse(rv, oe);
        check("R8 no write with cs high", rv, 8'h11);

        // R7: write completes in the cycle the burst ends
        set_addr(7'd10);
        data_in = 8'h5A; wr_n = 1'b0; wait_n(4);
        addr = 7'd20; ale = 1'b1; wr_n = 1'b1; wait_n(4);
        ale = 1'b0; wait_n(4);
        rd_pulse(rv, oe);
        check("R7 latch follows pins", rv, 8'h6E);
        set_addr(7'd10);
        rd_pulse(rv, oe);
        check("R7 write at old address", rv, 8'h5A);

        // R1: after reset, no burst, accesses hit entry 0
        do_reset();
        cs_n = 1'b0;
        wr_pulse(8'h77);
        wr_pulse(8'h88);
        rd_pulse(rv, oe);
        check("R1 entry 0 no advance", rv, 8'h88);
        rd_pulse(rv, oe);
        check("R1 read no advance", rv, 8'h88);
        set_addr(7'd1);
        rd_pulse(rv, oe);
        check("R1 entry 1 untouched", rv, 8'hA3);

        cs_n = 1'b1; wait_n(4);
        check("R4 oe low at end", {7'd0, data_oe}, 8'h00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule